// File: doc/BRIEF.md
# FIFO Flag Offset Loader

This block fills the four almost-full and almost-empty threshold registers of a dual-FIFO device once master reset is released. The offsets are loaded either as a bit stream on a dedicated serial data and enable pair, or as whole words on the port-A data bus. Two select inputs choose the method. They are captured on the first port-A clock edge after reset and keep that meaning until the next reset.

The offsets always load in one fixed cross-port order. Slot 0 is the port-A almost-full threshold, slot 1 the port-B almost-empty threshold, slot 2 the port-C almost-full threshold and slot 3 the port-A almost-empty threshold. Load cycles may have any number of idle clocks between them. When the last unit is stored, a sticky ready level rises in the port-A clock domain, and a two-flop synchronizer carries it into the port-C clock domain. Until that ready level is high, port-A write attempts are blocked from the FIFO. After it goes high, the offsets are frozen and qualified port-A writes pass through as FIFO data writes.

Top module: `flo_top`

## Requirements
- R1: While rst_ni is low, all four offset outputs are zero, and rdy_a_o, rdy_c_o and fifo_wr_o are low.
- R2: On the first clk_a_i rising edge after rst_ni goes high, mode_sel_i is captured: 2'b00 selects parallel loading and any other value selects serial loading. Later changes of mode_sel_i have no effect until the next reset. Nothing loads on that capturing edge.
- R3: In serial mode, each later clk_a_i edge with ser_en_i high stores one ser_d_i bit. Stream bit n (counting from 0) lands in slot n/W at bit position W-1-(n mod W), where W is the offset width. The stream therefore begins with the MSB of ofs_y1_o and ends with the LSB of ofs_x2_o, and it is 4*W bits long. Bits that are not yet loaded read as zero.
- R4: A clk_a_i edge during loading with neither a serial bit nor a qualified parallel write leaves all offsets unchanged.
- R5: In parallel mode, a qualified write (en_a_i=1, cs_a_ni=0, wr_a_i=1, mb_a_i=0) stores data_a_i into the next slot in the order y1, x1, y2, x2. Cycles that fail any of the four qualifiers are ignored, and ser_en_i is ignored in this mode.
- R6: rdy_a_o rises in the cycle after the edge that stores the last offset unit, and it stays high until reset.
- R7: fifo_wr_o is high exactly when a qualified write is presented while rdy_a_o is high. In parallel mode, the qualified write after the fourth offset is the first FIFO word. Qualified writes before ready never reach the FIFO, and in serial mode they do not change the offsets.
- R8: Once rdy_a_o is high, serial bits and qualified writes no longer change any offset.
- R9: rdy_c_o is never high while rdy_a_o is low. It goes high within three clk_c_i rising edges after rdy_a_o is high, and it then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | Port-A clock; all loading runs on it |
| clk_c_i | input | 1 | Port-C clock for the synchronized ready flag |
| rst_ni | input | 1 | Active-low asynchronous master reset for both domains |
| mode_sel_i | input | 2 | Load method select, captured after reset (00 parallel, else serial) |
| ser_en_i | input | 1 | Serial bit enable |
| ser_d_i | input | 1 | Serial bit data |
| data_a_i | input | OFS_W | Port-A data bus carrying parallel offset words |
| en_a_i | input | 1 | Port-A write enable |
| cs_a_ni | input | 1 | Port-A chip select, active low |
| wr_a_i | input | 1 | Port-A write direction (1 = write) |
| mb_a_i | input | 1 | Port-A mailbox select; must be 0 for offset and FIFO writes |
| ofs_y1_o | output | OFS_W | Port-A almost-full offset (slot 0) |
| ofs_x1_o | output | OFS_W | Port-B almost-empty offset (slot 1) |
| ofs_y2_o | output | OFS_W | Port-C almost-full offset (slot 2) |
| ofs_x2_o | output | OFS_W | Port-A almost-empty offset (slot 3) |
| rdy_a_o | output | 1 | Programming complete, port-A domain |
| rdy_c_o | output | 1 | Programming complete, port-C domain |
| fifo_wr_o | output | 1 | Qualified port-A write released to FIFO1 |

## Verification
On every cycle, the assertions check that the load counter stays within the unit count of the latched mode, that the mode cannot change after capture, and that the ready levels stay high once set. They also check that idle cycles and the post-ready state leave the offsets untouched, and that the port-C flag never runs ahead of the port-A flag. Only the bench scenarios can show that each stream bit and each parallel word reaches its slot and position in the required order. The same holds for the exact cycle in which ready appears and the first FIFO word is released, and for a reset in the middle of a stream restarting the sequence under a newly captured mode.

// File: rtl/flo_pkg.sv
package flo_pkg;
  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;
endpackage

// File: rtl/flo_ctrl.sv
module flo_ctrl
  import flo_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int NUM_OFS = 4,
  localparam int TOT_BITS = OFS_W * NUM_OFS,
  localparam int CNT_W    = $clog2(TOT_BITS + 1),
  localparam int IDX_W    = $clog2(NUM_OFS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_sel_i,
  input  logic             ser_en_i,
  input  logic             par_wr_i,
  output logic             bit_load_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             word_load_o,
  output logic [IDX_W-1:0] word_idx_o,
  output logic             ready_o
);
  logic             armed_q;
  load_mode_e       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;
  logic [CNT_W-1:0] limit;
  logic             step, last;

  assign limit       = (mode_q == LOAD_SER) ? CNT_W'(TOT_BITS) : CNT_W'(NUM_OFS);
  assign bit_load_o  = armed_q && !ready_q && (mode_q == LOAD_SER) && ser_en_i;
  assign word_load_o = armed_q && !ready_q && (mode_q == LOAD_PAR) && par_wr_i;
  assign step        = bit_load_o || word_load_o;
  assign last        = step && (cnt_q == limit - 1'b1);
  assign bit_idx_o   = cnt_q;
  assign word_idx_o  = cnt_q[IDX_W-1:0];
  assign ready_o     = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      mode_q  <= LOAD_PAR;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      if (!armed_q) begin
        armed_q <= 1'b1;
        mode_q  <= (mode_sel_i == 2'b00) ? LOAD_PAR : LOAD_SER;
      end
      if (step) cnt_q <= cnt_q + 1'b1;
      if (last) ready_q <= 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);
  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> $stable(mode_q));
  p_ready_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> ready_q);
  p_ready_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(cnt_q) == limit - 1'b1);
endmodule

// File: rtl/flo_regs.sv
module flo_regs #(
  parameter int OFS_W   = 8,
  parameter int NUM_OFS = 4,
  localparam int TOT_BITS = OFS_W * NUM_OFS,
  localparam int CNT_W    = $clog2(TOT_BITS + 1),
  localparam int IDX_W    = $clog2(NUM_OFS),
  localparam int POS_W    = $clog2(OFS_W)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bit_load_i,
  input  logic [CNT_W-1:0]                bit_idx_i,
  input  logic                            bit_d_i,
  input  logic                            word_load_i,
  input  logic [IDX_W-1:0]                word_idx_i,
  input  logic [OFS_W-1:0]                word_d_i,
  output logic [NUM_OFS-1:0][OFS_W-1:0]   ofs_o
);
  logic [OFS_W-1:0] slot_q [NUM_OFS];
  logic [CNT_W-1:0] bit_slot, bit_rem;
  logic [POS_W-1:0] bit_pos;

  // stream bits land MSB first inside each slot
  assign bit_slot = bit_idx_i / CNT_W'(OFS_W);
  assign bit_rem  = bit_idx_i % CNT_W'(OFS_W);
  assign bit_pos  = POS_W'(CNT_W'(OFS_W - 1) - bit_rem);

  for (genvar k = 0; k < NUM_OFS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[k] <= '0;
      end else if (word_load_i && word_idx_i == IDX_W'(k)) begin
        slot_q[k] <= word_d_i;
      end else if (bit_load_i && bit_slot == CNT_W'(k)) begin
        slot_q[k][bit_pos] <= bit_d_i;
      end
    end
    assign ofs_o[k] = slot_q[k];
  end

  p_one_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_load_i && word_load_i));
  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_load_i && !word_load_i) |=> $stable(ofs_o));
endmodule

// File: rtl/flo_sync.sv
module flo_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  p_sync_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |=> sync_q);
endmodule

// File: rtl/flo_top.sv
module flo_top #(
  parameter int OFS_W = 8
) (
  input  logic             clk_a_i,
  input  logic             clk_c_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_sel_i,
  input  logic             ser_en_i,
  input  logic             ser_d_i,
  input  logic [OFS_W-1:0] data_a_i,
  input  logic             en_a_i,
  input  logic             cs_a_ni,
  input  logic             wr_a_i,
  input  logic             mb_a_i,
  output logic [OFS_W-1:0] ofs_y1_o,
  output logic [OFS_W-1:0] ofs_x1_o,
  output logic [OFS_W-1:0] ofs_y2_o,
  output logic [OFS_W-1:0] ofs_x2_o,
  output logic             rdy_a_o,
  output logic             rdy_c_o,
  output logic             fifo_wr_o
);
  localparam int NUM_OFS  = 4;  // load order is fixed: y1, x1, y2, x2
  localparam int TOT_BITS = OFS_W * NUM_OFS;
  localparam int CNT_W    = $clog2(TOT_BITS + 1);
  localparam int IDX_W    = $clog2(NUM_OFS);

  logic                          qual_wr;
  logic                          bit_load, word_load;
  logic [CNT_W-1:0]              bit_idx;
  logic [IDX_W-1:0]              word_idx;
  logic                          ready_a;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs;

  assign qual_wr = en_a_i && !cs_a_ni && wr_a_i && !mb_a_i;

  flo_ctrl #(.OFS_W(OFS_W), .NUM_OFS(NUM_OFS)) u_ctrl (
    .clk_i       (clk_a_i),
    .rst_ni      (rst_ni),
    .mode_sel_i  (mode_sel_i),
    .ser_en_i    (ser_en_i),
    .par_wr_i    (qual_wr),
    .bit_load_o  (bit_load),
    .bit_idx_o   (bit_idx),
    .word_load_o (word_load),
    .word_idx_o  (word_idx),
    .ready_o     (ready_a)
  );

  flo_regs #(.OFS_W(OFS_W), .NUM_OFS(NUM_OFS)) u_regs (
    .clk_i       (clk_a_i),
    .rst_ni      (rst_ni),
    .bit_load_i  (bit_load),
    .bit_idx_i   (bit_idx),
    .bit_d_i     (ser_d_i),
    .word_load_i (word_load),
    .word_idx_i  (word_idx),
    .word_d_i    (data_a_i),
    .ofs_o       (ofs)
  );

  flo_sync u_sync_c (
    .clk_i  (clk_c_i),
    .rst_ni (rst_ni),
    .d_i    (ready_a),
    .q_o    (rdy_c_o)
  );

  assign ofs_y1_o  = ofs[0];
  assign ofs_x1_o  = ofs[1];
  assign ofs_y2_o  = ofs[2];
  assign ofs_x2_o  = ofs[3];
  assign rdy_a_o   = ready_a;
  assign fifo_wr_o = qual_wr && ready_a;

  p_frozen_r8: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    ready_a |=> $stable(ofs));
  p_rdy_c_after_a_r9: assert property (@(posedge clk_c_i) disable iff (!rst_ni)
    rdy_c_o |-> ready_a);
endmodule

// File: tb/sim_flo_top.sv
`timescale 1ns/1ps
module sim_flo_top;
  localparam int W = 8;

  logic clk_a_i = 1'b0, clk_c_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_sel_i = 2'b00;
  logic ser_en_i = 0, ser_d_i = 0, en_a_i = 0, cs_a_ni = 1, wr_a_i = 0, mb_a_i = 0;
  logic [W-1:0] data_a_i = '0;
  logic [W-1:0] ofs_y1_o, ofs_x1_o, ofs_y2_o, ofs_x2_o;
  logic rdy_a_o, rdy_c_o, fifo_wr_o;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  flo_top #(.OFS_W(W)) u0 (.*);

  always #2.5 clk_a_i = ~clk_a_i;
  initial begin #1.3; forever #3.5 clk_c_i = ~clk_c_i; end

  // behavioural reference
  bit m_armed, m_ser, m_rdy;
  int m_cnt;
  logic [W-1:0] m_ofs [4];
  int c_cnt;

  function automatic bit qual();
    return en_a_i && !cs_a_ni && wr_a_i && !mb_a_i;
  endfunction

  always @(posedge clk_a_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_armed = 0; m_ser = 0; m_rdy = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) m_ofs[i] = '0;
    end else if (!m_armed) begin
      m_armed = 1;
      m_ser = (mode_sel_i != 2'b00);
    end else if (!m_rdy) begin
      if (m_ser && ser_en_i) begin
        m_ofs[m_cnt / W][W - 1 - (m_cnt % W)] = ser_d_i;
        m_cnt++;
        if (m_cnt == 4 * W) m_rdy = 1;
      end else if (!m_ser && qual()) begin
        m_ofs[m_cnt] = data_a_i;
        m_cnt++;
        if (m_cnt == 4) m_rdy = 1;
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk_a_i) if (!done) begin
    chk(cur_req, "y1", 32'(ofs_y1_o), 32'(m_ofs[0]));
    chk(cur_req, "x1", 32'(ofs_x1_o), 32'(m_ofs[1]));
    chk(cur_req, "y2", 32'(ofs_y2_o), 32'(m_ofs[2]));
    chk(cur_req, "x2", 32'(ofs_x2_o), 32'(m_ofs[3]));
    chk("R6", "rdy_a", 32'(rdy_a_o), 32'(m_rdy));
    chk("R7", "fifo_wr", 32'(fifo_wr_o), 32'(m_rdy && qual()));
  end

  always @(posedge clk_c_i or negedge rst_ni) begin
    if (!rst_ni) c_cnt = 0;
    else if (m_rdy) c_cnt++;
  end

  always @(negedge clk_c_i) if (!done) begin
    if (!m_rdy) chk("R9", "rdy_c early", 32'(rdy_c_o), 0);
    else if (c_cnt >= 3) chk("R9", "rdy_c late", 32'(rdy_c_o), 1);
  end

  task automatic cyc(logic se, logic sd, logic en, logic csn, logic wr, logic mb,
                     logic [W-1:0] d);
    @(posedge clk_a_i); #1;
    ser_en_i = se; ser_d_i = sd; en_a_i = en; cs_a_ni = csn;
    wr_a_i = wr; mb_a_i = mb; data_a_i = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 0, '0);
  endtask

  task automatic pwr(logic [W-1:0] d);
    cyc(0, 0, 1, 0, 1, 0, d);
  endtask

  task automatic do_reset(logic [1:0] ms);
    @(posedge clk_a_i); #1;
    rst_ni = 0; mode_sel_i = ms;
    cur_req = "R1";
    idle(3);
    chk("R1", "rdy_a in reset", 32'(rdy_a_o), 0);
    chk("R1", "rdy_c in reset", 32'(rdy_c_o), 0);
    chk("R1", "y1 in reset", 32'(ofs_y1_o), 0);
    rst_ni = 1;  // released at edge+1; next edge captures mode
  endtask

  task automatic send_ser(logic [4*W-1:0] v, int gap, bit poke);
    for (int i = 4 * W - 1; i >= 0; i--) begin
      cyc(1, v[i], 0, 1, 0, 0, '0);
      if (i % gap == 0) begin
        if (poke) pwr(8'hFF); else idle(1);
      end
    end
  endtask

  initial begin
    // parallel load with rejected qualifiers
    do_reset(2'b00);
    cur_req = "R2";
    idle(1);
    cur_req = "R5";
    cyc(0, 0, 0, 0, 1, 0, 8'h11);
    cyc(0, 0, 1, 1, 1, 0, 8'h22);
    cyc(0, 0, 1, 0, 0, 0, 8'h33);
    cyc(0, 0, 1, 0, 1, 1, 8'h44);
    cyc(1, 1, 0, 1, 0, 0, '0);
    pwr(8'hA5);
    cur_req = "R4"; idle(2);
    cur_req = "R5";
    pwr(8'h3C); pwr(8'hF0); idle(1); pwr(8'h0F);
    cur_req = "R7";
    pwr(8'h99);
    cur_req = "R8";
    cyc(1, 1, 0, 1, 0, 0, '0);
    pwr(8'h55);
    idle(6);
    #1;
    chk("R5", "par y1", 32'(ofs_y1_o), 32'hA5);
    chk("R5", "par x1", 32'(ofs_x1_o), 32'h3C);
    chk("R5", "par y2", 32'(ofs_y2_o), 32'hF0);
    chk("R5", "par x2", 32'(ofs_x2_o), 32'h0F);
    chk("R6", "rdy_a set", 32'(rdy_a_o), 1);
    chk("R9", "rdy_c set", 32'(rdy_c_o), 1);

    // serial with gaps and blocked writes; select changes after capture
    do_reset(2'b01);
    cur_req = "R2";
    idle(1);
    mode_sel_i = 2'b00;
    cur_req = "R3";
    send_ser(32'h817E12C4, 5, 1);
    cur_req = "R7";
    pwr(8'h66);
    cur_req = "R8";
    send_ser(32'hFFFFFFFF, 8, 0);
    idle(5);
    #1;
    chk("R3", "ser y1", 32'(ofs_y1_o), 32'h81);
    chk("R3", "ser x1", 32'(ofs_x1_o), 32'h7E);
    chk("R3", "ser y2", 32'(ofs_y2_o), 32'h12);
    chk("R3", "ser x2", 32'(ofs_x2_o), 32'hC4);
    chk("R9", "rdy_c ser", 32'(rdy_c_o), 1);

    // partial stream, reset restarts under a new select value
    do_reset(2'b10);
    idle(1);
    cur_req = "R3";
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 1, 0, 0, '0);
    idle(1);
    #1;
    chk("R3", "partial y1", 32'(ofs_y1_o), 32'hFF);
    chk("R3", "partial x1", 32'(ofs_x1_o), 32'hC0);
    chk("R6", "partial rdy", 32'(rdy_a_o), 0);
    do_reset(2'b11);
    idle(1);
    cur_req = "R3";
    send_ser(32'h0102A0FE, 32, 0);
    cur_req = "R7";
    pwr(8'h01);
    idle(5);
    #1;
    chk("R3", "restart y1", 32'(ofs_y1_o), 32'h01);
    chk("R3", "restart x2", 32'(ofs_x2_o), 32'hFE);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog R6 act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule